// File: doc/BRIEF.md
# Frame-Synchronized Control Register Bank

This block is the software-facing configuration store of an image-processing engine. One bus port with address, write data and byte enables reaches four classes of register. Immediate registers take a write whenever it arrives. Shadowed registers hold a pending copy that software may rewrite at any point in a frame, and an active copy that the datapath uses. Lock-while-busy registers discard writes while the engine reports busy. A read-only window stands in for memory-backed storage inside the engine.

Every access completes with a one-cycle acknowledge, including writes that the bank discards. The engine supplies three signals. Busy gates the lock class and the memory window. A one-cycle end-of-frame pulse moves the pending shadow values into the active set and raises a sticky interrupt flag. Enable selects the shadow mode: when it is low, the active set tracks the pending set on every cycle, so software can stop the engine, reprogram it and start it again without waiting for a frame boundary.

Top module: `fsync_regbank`

## Requirements
- R1: Immediate registers (address page 1, word index 0..N_IMM-1) take a write whether busy is high or low. Only the bytes whose enable bit is 1 change, and the new value is on `imm_cfg` in the cycle after the write edge.
- R2: While `eng_busy` is 1, a write to a lock register (page 3) leaves `lck_cfg` and its readback unchanged.
- R3: While `eng_busy` is 0, a write to a lock register updates its enabled bytes on the following cycle.
- R4: With `eng_en` at 1 and no end-of-frame pulse, a shadow write (page 2) changes the pending value returned by reads and leaves `shd_cfg` unchanged.
- R5: With `eng_en` at 1, an `eng_eof` pulse copies every pending shadow value into `shd_cfg`. A shadow write made in the same cycle as the pulse is part of the copied value.
- R6: With `eng_en` at 0, `shd_cfg` equals the pending shadow values from the cycle after each write.
- R7: Each cycle with `req` high gives `ack` high on the next cycle, with no error indication, whatever the address, class or busy state. `ack` is low otherwise.
- R8: An address outside the map reads as zero, and writing it changes no output. The map is: page = addr[7:4], index = addr[3:0]; page 0 index 0 is the flag; pages 1/2/3 hold registers at index < N; page 4 is the window.
- R9: A read of the memory window (page 4) returns 0xDEADBEEF while busy. While idle it returns {8'hC3, 4'h0, idx, 4'hF, ~idx, 8'h5A}. Byte enables do not affect either case, and writes to the window are ignored.
- R10: An `eng_eof` pulse sets `irq_flag`. A write to page 0 index 0 with byte enable 0 set and wdata bit 0 set clears it. A set in the same cycle as a clear leaves the flag set. The flag reads back on data bit 0.
- R11: After reset, all configuration outputs, `irq_flag`, `ack` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW (8) | Word address: page in [7:4], index in [3:0] |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables for writes |
| ack | output | 1 | Access complete, one cycle after req |
| rdata | output | 32 | Read data, valid with ack of a read |
| eng_busy | input | 1 | Engine busy |
| eng_eof | input | 1 | End-of-frame pulse |
| eng_en | input | 1 | Engine enabled; selects frame-synchronized shadow update |
| imm_cfg | output | N_IMM*32 | Immediate register values |
| shd_cfg | output | N_SHD*32 | Active shadowed register values |
| lck_cfg | output | N_LCK*32 | Lock-while-busy register values |
| irq_flag | output | 1 | Sticky end-of-frame flag |

## Verification
The outputs expose every stored register directly, so a wrong value in any immediate, lock or active shadow word appears on the configuration buses one cycle after the edge that caused it. The pending shadow copies have no output of their own. A fault there shows only on a later read, or on the active outputs at the next end-of-frame pulse or while the engine is disabled. A wrong class decode therefore appears either on the outputs at the next write or in the read data one cycle after a read of the affected address.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int FSR_DW = 32;
  localparam int FSR_BW = FSR_DW / 8;
  localparam int FSR_IW = 4;

  localparam int PG_IRQ = 0;
  localparam int PG_IMM = 1;
  localparam int PG_SHD = 2;
  localparam int PG_LCK = 3;
  localparam int PG_MEM = 4;

  typedef enum logic [2:0] {
    CLS_IRQ,
    CLS_IMM,
    CLS_SHD,
    CLS_LCK,
    CLS_MEM,
    CLS_NONE
  } fsr_cls_e;

  // Replace only the bytes whose enable bit is set.
  function automatic logic [FSR_DW-1:0] be_merge(input logic [FSR_DW-1:0] old_w,
                                                 input logic [FSR_DW-1:0] new_w,
                                                 input logic [FSR_BW-1:0] be);
    logic [FSR_DW-1:0] r;
    for (int b = 0; b < FSR_BW; b++)
      r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    return r;
  endfunction

  // Placeholder content of the memory window.
  function automatic logic [FSR_DW-1:0] stub_word(input logic [FSR_IW-1:0] ix);
    return {8'hC3, 4'h0, ix, 4'hF, ~ix, 8'h5A};
  endfunction
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
  import fsr_pkg::*;
#(
  parameter int AW    = 8,
  parameter int N_IMM = 4,
  parameter int N_SHD = 4,
  parameter int N_LCK = 4,
  parameter int N_MEM = 16
) (
  input  logic [AW-1:0]     addr,
  output fsr_cls_e          cls,
  output logic [FSR_IW-1:0] idx
);
  localparam int PW = AW - FSR_IW;

  logic [PW-1:0] page;
  assign page = addr[AW-1:FSR_IW];
  assign idx  = addr[FSR_IW-1:0];

  function automatic logic in_range(input logic [FSR_IW-1:0] i, input int n);
    return int'(i) < n;
  endfunction

  always_comb begin
    cls = CLS_NONE;
    case (int'(page))
      PG_IRQ: if (idx == '0) cls = CLS_IRQ;
      PG_IMM: if (in_range(idx, N_IMM)) cls = CLS_IMM;
      PG_SHD: if (in_range(idx, N_SHD)) cls = CLS_SHD;
      PG_LCK: if (in_range(idx, N_LCK)) cls = CLS_LCK;
      PG_MEM: if (in_range(idx, N_MEM)) cls = CLS_MEM;
      default: cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/fsr_word.sv
module fsr_word
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [FSR_DW-1:0] wdata,
  input  logic [FSR_BW-1:0] be,
  output logic [FSR_DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= be_merge(q, wdata, be);
  end
endmodule

// File: rtl/fsr_shadow_bank.sv
module fsr_shadow_bank
  import fsr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wr,
  input  logic [FSR_DW-1:0] wdata,
  input  logic [FSR_BW-1:0] be,
  input  logic              load,
  output logic [FSR_DW-1:0] pend [N],
  output logic [FSR_DW-1:0] act  [N]
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [FSR_DW-1:0] pend_nxt;
    assign pend_nxt = wr[g] ? be_merge(pend[g], wdata, be) : pend[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= '0;
        act[g]  <= '0;
      end else begin
        pend[g] <= pend_nxt;
        if (load) act[g] <= pend_nxt;
      end
    end
  end
endmodule

// File: rtl/fsr_mem_stub.sv
module fsr_mem_stub
  import fsr_pkg::*;
#(
  parameter logic [FSR_DW-1:0] POISON = 32'hDEAD_BEEF
) (
  input  logic              busy,
  input  logic [FSR_IW-1:0] idx,
  output logic [FSR_DW-1:0] word
);
  assign word = busy ? POISON : stub_word(idx);
endmodule

// File: rtl/fsync_regbank.sv
module fsync_regbank
  import fsr_pkg::*;
#(
  parameter int                AW     = 8,
  parameter int                N_IMM  = 4,
  parameter int                N_SHD  = 4,
  parameter int                N_LCK  = 4,
  parameter int                N_MEM  = 16,
  parameter logic [FSR_DW-1:0] POISON = 32'hDEAD_BEEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [FSR_DW-1:0]       wdata,
  input  logic [FSR_BW-1:0]       be,
  output logic                    ack,
  output logic [FSR_DW-1:0]       rdata,
  input  logic                    eng_busy,
  input  logic                    eng_eof,
  input  logic                    eng_en,
  output logic [N_IMM*FSR_DW-1:0] imm_cfg,
  output logic [N_SHD*FSR_DW-1:0] shd_cfg,
  output logic [N_LCK*FSR_DW-1:0] lck_cfg,
  output logic                    irq_flag
);
  localparam int DW  = FSR_DW;
  localparam int IMW = $clog2(N_IMM);
  localparam int SHW = $clog2(N_SHD);
  localparam int LKW = $clog2(N_LCK);

  fsr_cls_e          cls;
  logic [FSR_IW-1:0] idx;

  fsr_decode #(.AW(AW), .N_IMM(N_IMM), .N_SHD(N_SHD), .N_LCK(N_LCK), .N_MEM(N_MEM)) u_dec (
    .addr(addr), .cls(cls), .idx(idx)
  );

  // Named internal events
  logic wr, rd, lck_drop, shd_xfer, shd_load, irq_clr, rd_none, rd_mem_busy;
  assign wr          = req & we;
  assign rd          = req & ~we;
  assign lck_drop    = wr & (cls == CLS_LCK) & eng_busy;
  assign shd_xfer    = eng_en & eng_eof;
  assign shd_load    = shd_xfer | ~eng_en;
  assign irq_clr     = wr & (cls == CLS_IRQ) & be[0] & wdata[0];
  assign rd_none     = rd & (cls == CLS_NONE);
  assign rd_mem_busy = rd & (cls == CLS_MEM) & eng_busy;

  // Immediate class
  logic [DW-1:0] imm_q [N_IMM];
  for (genvar g = 0; g < N_IMM; g++) begin : g_imm
    logic hit;
    assign hit = wr & (cls == CLS_IMM) & (idx == FSR_IW'(g));
    fsr_word u_w (.clk(clk), .rst_n(rst_n), .wr(hit), .wdata(wdata), .be(be), .q(imm_q[g]));
    assign imm_cfg[g*DW +: DW] = imm_q[g];
  end

  // Lock-while-busy class
  logic [DW-1:0] lck_q [N_LCK];
  for (genvar g = 0; g < N_LCK; g++) begin : g_lck
    logic hit;
    assign hit = wr & (cls == CLS_LCK) & ~eng_busy & (idx == FSR_IW'(g));
    fsr_word u_w (.clk(clk), .rst_n(rst_n), .wr(hit), .wdata(wdata), .be(be), .q(lck_q[g]));
    assign lck_cfg[g*DW +: DW] = lck_q[g];
  end

  // Shadowed class
  logic [N_SHD-1:0]      shd_wr;
  logic [DW-1:0]         shd_pend [N_SHD];
  logic [DW-1:0]         shd_act  [N_SHD];
  logic [N_SHD*DW-1:0]   shd_pend_flat;
  for (genvar g = 0; g < N_SHD; g++) begin : g_shd
    assign shd_wr[g] = wr & (cls == CLS_SHD) & (idx == FSR_IW'(g));
    assign shd_cfg[g*DW +: DW]       = shd_act[g];
    assign shd_pend_flat[g*DW +: DW] = shd_pend[g];
  end

  fsr_shadow_bank #(.N(N_SHD)) u_shd (
    .clk(clk), .rst_n(rst_n), .wr(shd_wr), .wdata(wdata), .be(be),
    .load(shd_load), .pend(shd_pend), .act(shd_act)
  );

  // Memory window stub
  logic [DW-1:0] mem_word;
  fsr_mem_stub #(.POISON(POISON)) u_mem (.busy(eng_busy), .idx(idx), .word(mem_word));

  // Sticky flag: a set in the same cycle as a clear wins
  logic irq_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (eng_eof) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end
  assign irq_flag = irq_q;

  // Read path
  logic [DW-1:0] rd_word;
  always_comb begin
    case (cls)
      CLS_IRQ: rd_word = {{(DW-1){1'b0}}, irq_q};
      CLS_IMM: rd_word = imm_q[idx[IMW-1:0]];
      CLS_SHD: rd_word = shd_pend[idx[SHW-1:0]];
      CLS_LCK: rd_word = lck_q[idx[LKW-1:0]];
      CLS_MEM: rd_word = mem_word;
      default: rd_word = '0;
    endcase
  end

  logic          ack_q;
  logic [DW-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= req;
      if (rd) rdata_q <= rd_word;
    end
  end
  assign ack   = ack_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk
  import fsr_pkg::*;
#(
  parameter int                N_SHD  = 4,
  parameter int                N_LCK  = 4,
  parameter logic [FSR_DW-1:0] POISON = 32'hDEAD_BEEF
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req,
  input logic                    ack,
  input logic [FSR_DW-1:0]       rdata,
  input logic                    eng_eof,
  input logic                    eng_en,
  input logic                    irq_flag,
  input logic                    lck_drop,
  input logic                    shd_xfer,
  input logic                    rd_none,
  input logic                    rd_mem_busy,
  input logic [N_SHD*FSR_DW-1:0] shd_cfg,
  input logic [N_SHD*FSR_DW-1:0] shd_pend,
  input logic [N_LCK*FSR_DW-1:0] lck_cfg
);
  // R2
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lck_drop |=> $stable(lck_cfg));

  // R7
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);

  // R7
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ack);

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && !eng_eof) |=> $stable(shd_cfg));

  // R5
  shadow_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shd_xfer |=> (shd_cfg == shd_pend));

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_eof |=> irq_flag);

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none |=> (rdata == '0));

  // R9
  mem_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mem_busy |=> (rdata == POISON));
endmodule

bind fsync_regbank fsr_chk #(.N_SHD(N_SHD), .N_LCK(N_LCK), .POISON(POISON)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .rdata(rdata),
  .eng_eof(eng_eof), .eng_en(eng_en), .irq_flag(irq_flag),
  .lck_drop(lck_drop), .shd_xfer(shd_xfer), .rd_none(rd_none),
  .rd_mem_busy(rd_mem_busy), .shd_cfg(shd_cfg), .shd_pend(shd_pend_flat),
  .lck_cfg(lck_cfg)
);

// File: tb/sim_fsync_regbank.sv
module sim_fsync_regbank;
  localparam int N = 4;
  localparam logic [31:0] POISON = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic eng_busy = 1'b0, eng_eof = 1'b0, eng_en = 1'b1;
  logic ack, irq_flag;
  logic [31:0] rdata;
  logic [N*32-1:0] imm_cfg, shd_cfg, lck_cfg;

  always #10 clk = ~clk;  // 50 MHz

  fsync_regbank u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .be(be), .ack(ack), .rdata(rdata), .eng_busy(eng_busy), .eng_eof(eng_eof),
    .eng_en(eng_en), .imm_cfg(imm_cfg), .shd_cfg(shd_cfg), .lck_cfg(lck_cfg),
    .irq_flag(irq_flag)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] imm_m [N], pend_m [N], act_m [N], lck_m [N];
  logic        irq_m;
  logic [31:0] rdata_m;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] b);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (b[k]) r[k*8 +: 8] = n[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] window_word(input logic [3:0] ix);
    return {8'hC3, 4'h0, ix, 4'hF, ~ix, 8'h5A};
  endfunction

  function automatic logic [31:0] read_model(input logic [7:0] a, input logic bz);
    logic [3:0] pg = a[7:4];
    logic [3:0] ix = a[3:0];
    case (pg)
      4'd0: return (ix == 0) ? {31'b0, irq_m} : 32'h0;
      4'd1: return (ix < N) ? imm_m[ix[1:0]] : 32'h0;
      4'd2: return (ix < N) ? pend_m[ix[1:0]] : 32'h0;
      4'd3: return (ix < N) ? lck_m[ix[1:0]] : 32'h0;
      4'd4: return bz ? POISON : window_word(ix);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a[7:4])
      4'd0: return "R10";
      4'd1: return "R1";
      4'd2: return "R4";
      4'd3: return "R3";
      4'd4: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs(input logic wrote_lck_busy, input logic ef, input logic en);
    for (int i = 0; i < N; i++) begin
      chk(imm_cfg[i*32 +: 32] === imm_m[i], "R1", imm_cfg[i*32 +: 32], imm_m[i]);
      chk(shd_cfg[i*32 +: 32] === act_m[i], !en ? "R6" : (ef ? "R5" : "R4"),
          shd_cfg[i*32 +: 32], act_m[i]);
      chk(lck_cfg[i*32 +: 32] === lck_m[i], wrote_lck_busy ? "R2" : "R3",
          lck_cfg[i*32 +: 32], lck_m[i]);
    end
    chk(irq_flag === irq_m, "R10", {31'b0, irq_flag}, {31'b0, irq_m});
  endtask

  // One bus cycle: drive, model the edge, check at the following negedge.
  task automatic step(input logic r, input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] b, input logic bz, input logic ef, input logic en);
    logic [3:0] ix;
    logic lck_busy_wr;
    req = r; we = w; addr = a; wdata = d; be = b;
    eng_busy = bz; eng_eof = ef; eng_en = en;
    @(posedge clk);
    ix = a[3:0];
    lck_busy_wr = 1'b0;
    if (r && !w) rdata_m = read_model(a, bz);
    if (r && w) begin
      case (a[7:4])
        4'd0: if (ix == 0 && b[0] && d[0]) irq_m = 1'b0;
        4'd1: if (ix < N) imm_m[ix[1:0]] = merge(imm_m[ix[1:0]], d, b);
        4'd2: if (ix < N) pend_m[ix[1:0]] = merge(pend_m[ix[1:0]], d, b);
        4'd3: if (ix < N) begin
                if (bz) lck_busy_wr = 1'b1;
                else    lck_m[ix[1:0]] = merge(lck_m[ix[1:0]], d, b);
              end
        default: ;
      endcase
    end
    if (ef) irq_m = 1'b1;
    if (!en || ef) for (int i = 0; i < N; i++) act_m[i] = pend_m[i];
    @(negedge clk);
    chk(ack === r, "R7", {31'b0, ack}, {31'b0, r});
    if (r && !w) chk(rdata === rdata_m, rd_tag(a), rdata, rdata_m);
    compare_outputs(lck_busy_wr, ef, en);
    req = 1'b0; eng_eof = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      imm_m[i] = '0; pend_m[i] = '0; act_m[i] = '0; lck_m[i] = '0;
    end
    irq_m = 1'b0; rdata_m = '0;
    void'($urandom(32'd7103));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ack === 1'b0 && rdata === '0, "R11", rdata, 32'h0);
    chk(imm_cfg === '0 && shd_cfg === '0 && lck_cfg === '0 && irq_flag === 1'b0,
        "R11", imm_cfg[31:0] | shd_cfg[31:0] | lck_cfg[31:0], 32'h0);

    // R1: partial byte write while busy
    step(1, 1, 8'h10, 32'h1122_3344, 4'b0101, 1, 0, 1);
    step(1, 0, 8'h10, 32'h0, 4'b0000, 1, 0, 1);
    // R2: lock write while busy is dropped but acknowledged
    step(1, 1, 8'h31, 32'hAAAA_5555, 4'hF, 1, 0, 1);
    step(1, 0, 8'h31, 32'h0, 4'hF, 1, 0, 1);
    // R3: lock write while idle lands
    step(1, 1, 8'h31, 32'hAAAA_5555, 4'hF, 0, 0, 1);
    step(1, 0, 8'h31, 32'h0, 4'hF, 0, 0, 1);
    // R4: shadow write held until end of frame
    step(1, 1, 8'h22, 32'hCAFE_0001, 4'hF, 1, 0, 1);
    step(1, 0, 8'h22, 32'h0, 4'hF, 1, 0, 1);
    // R5: end of frame copies; then write coinciding with the pulse
    step(0, 0, 8'h00, 32'h0, 4'h0, 1, 1, 1);
    step(1, 1, 8'h23, 32'h0BAD_F00D, 4'hF, 1, 1, 1);
    // R6: engine disabled, active follows pending
    step(1, 1, 8'h20, 32'h1234_5678, 4'b0011, 0, 0, 0);
    step(0, 0, 8'h00, 32'h0, 4'h0, 0, 0, 1);
    // R8: unmapped write and read
    step(1, 1, 8'h75, 32'hFFFF_FFFF, 4'hF, 0, 0, 1);
    step(1, 0, 8'h75, 32'h0, 4'hF, 0, 0, 1);
    step(1, 0, 8'h14, 32'h0, 4'hF, 0, 0, 1);
    // R9: window with no byte enables, busy then idle, and an ignored write
    step(1, 0, 8'h47, 32'h0, 4'h0, 1, 0, 1);
    step(1, 0, 8'h47, 32'h0, 4'h0, 0, 0, 1);
    step(1, 1, 8'h47, 32'hFFFF_FFFF, 4'hF, 0, 0, 1);
    step(1, 0, 8'h47, 32'h0, 4'h0, 0, 0, 1);
    // R10: read flag, clear it, then clear and set together
    step(1, 0, 8'h00, 32'h0, 4'h0, 0, 0, 1);
    step(1, 1, 8'h00, 32'h1, 4'h1, 0, 0, 1);
    step(1, 0, 8'h00, 32'h0, 4'h0, 0, 0, 1);
    step(1, 1, 8'h00, 32'h1, 4'h1, 0, 1, 1);
    step(1, 1, 8'h00, 32'h1, 4'h0, 0, 0, 1);

    // Constrained random traffic
    for (int n = 0; n < 800; n++) begin
      logic [3:0] pg, ix;
      pg = 4'($urandom % 6);
      ix = 4'($urandom % 6);
      step(($urandom % 4) != 0, $urandom % 2, {pg, ix}, $urandom, 4'($urandom % 16),
           $urandom % 2, ($urandom % 8) == 0, ($urandom % 6) != 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule